// File: doc/BRIEF.md
# Programmable Watchdog with Reset Steering

The block is a watchdog timer driven by an external 16 Hz tick. Software programs one control byte, which holds a five-bit multiplier, a two-bit resolution and a steering bit. The countdown length in ticks is the multiplier times four raised to the resolution. Any write or read of the control byte restarts the countdown. If the countdown runs out, the block raises a sticky fired flag. The steering bit then selects the action: a one-clock system reset request, or a one-clock interrupt pulse.

A reset-steered expiry also disarms the watchdog. It clears the control byte to zero and clears the century bit held in an auxiliary byte. After any expiry the counter halts until software touches the control byte again. The flag byte cannot be written from the bus.

Control runs through a four-state machine:
- **OFF**: disabled. This is the reset state, and the state after the control byte is loaded with a zero multiplier.
- **RUN**: counting ticks.
- **FIRE**: the one-cycle expiry action.
- **HALT**: stopped after expiry.

The transitions are:
- *arm*: an access to the control byte with a nonzero multiplier moves any state to RUN and reloads the count.
- *disarm*: an access to the control byte with a zero multiplier moves any state to OFF.
- *tick-down*: RUN stays in RUN while ticks remain.
- *expire*: RUN moves to FIRE on the final tick.
- *settle*: FIRE moves to HALT on the next clock.
- *idle*: OFF and HALT hold.

Register map, selected by `bus_addr`:

| Address | Byte |
|---|---|
| 0 | Control byte: bit 7 steer, bits 6:2 multiplier, bits 1:0 resolution |
| 1 | Flag byte: bit 7 fired, read-only |
| 2 | Auxiliary byte: bit 6 century, read/write |
| 3 | Unused: reads zero, writes ignored |

Top module: `wdog_steer`

## Requirements
- R1: With multiplier M (control bits 6:2) and resolution S (bits 1:0), the expiry action appears in the cycle after the (M·4^S)-th tick that follows the last control access, and not earlier.
- R2: A control byte whose multiplier field is zero (for example 0x00 or 0x03) disables the watchdog; no tick produces an expiry.
- R3: A write to address 0 stores the byte, and reads at address 0 return it. The write clears the fired flag and restarts the countdown from the new value.
- R4: A read at address 0 returns the stored byte, restarts the countdown with it, and clears the fired flag.
- R5: On expiry, bit 7 of the flag byte (address 1) reads 1.
- R6: On expiry with control bit 7 set, `sys_reset_req` pulses high for exactly one clock. The control byte then reads 0x00, and the century bit (address 2, bit 6) reads 0.
- R7: On expiry with control bit 7 clear, `irq_pulse` pulses high for exactly one clock, and the control and auxiliary bytes keep their values.
- R8: Writes to address 1 have no effect on the flag byte, whose bits 6:0 always read 0.
- R9: After an expiry no further pulse appears, however many ticks arrive, until the control byte is accessed again.
- R10: Reset puts the block in OFF with both outputs low, all bytes zero and `rd_data` zero.
- R11: A control access takes priority over a tick in the same cycle. An access during the FIRE cycle also wins: the flag stays clear, and the countdown reloads from the value the control byte holds after that cycle.
- R12: Address 2 stores only bit 6 (other bits read 0). Address 3 reads 0x00 and ignores writes. Read data appears on `rd_data` one clock after `rd_en` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16hz | input | 1 | One-clock time-base strobe, 16 per second |
| bus_addr | input | 2 | Byte select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| sys_reset_req | output | 1 | One-clock system reset request |
| irq_pulse | output | 1 | One-clock interrupt pulse |

## Verification
The bench targets several corner cases, each tied to a specific fault it would expose:
- **Tick count at the boundary.** It counts ticks up to exactly one short of the programmed timeout, then to the timeout itself, including the largest setting of 1984 ticks. An off-by-one counter would fire early or late.
- **Zero multiplier with a nonzero resolution.** A design that treated only 0x00 as "off" would fire with no delay.
- **Access in the same cycle as a tick, and access during the FIRE cycle.** A design that let the tick or the expiry win would rearm from a stale count, set the flag after software cleared it, or restart a watchdog that the reset steering had just zeroed.
- **Random operation.** A long randomized run, checked against a cycle model, catches pulses that last two cycles or repeat after HALT, as well as flag writes that slip through.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Controller states of the watchdog
    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_FIRE = 2'd2,
        WD_HALT = 2'd3
    } wd_state_e;

    // Register selects on the byte bus
    localparam int unsigned SEL_CTRL = 0;
    localparam int unsigned SEL_FLAG = 1;
    localparam int unsigned SEL_AUX  = 2;

endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fire,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] ctrl_nxt,
    output logic              ctrl_acc,
    output logic              fired_q,
    output logic [DATA_W-1:0] rd_q
);
    import wdt_pkg::*;

    localparam int STEER_BIT = DATA_W - 1;
    localparam int FLAG_BIT  = DATA_W - 1;
    localparam int CENT_BIT  = DATA_W - 2;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(SEL_CTRL);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(SEL_FLAG);
    localparam logic [ADDR_W-1:0] A_AUX  = ADDR_W'(SEL_AUX);

    logic              cent_q;
    logic              cent_nxt;
    logic              fired_nxt;
    logic              steer_clear;
    logic              wr_ctrl;
    logic              wr_aux;
    logic [DATA_W-1:0] rd_mux;

    assign wr_ctrl     = wr_en && (bus_addr == A_CTRL);
    assign wr_aux      = wr_en && (bus_addr == A_AUX);
    assign ctrl_acc    = (wr_en || rd_en) && (bus_addr == A_CTRL);
    assign steer_clear = fire && ctrl_q[STEER_BIT];

    // Bus writes outrank the clear that a reset-steered expiry applies
    always_comb begin
        if (wr_ctrl) begin
            ctrl_nxt = wr_data;
        end else if (steer_clear) begin
            ctrl_nxt = '0;
        end else begin
            ctrl_nxt = ctrl_q;
        end
    end

    always_comb begin
        if (wr_aux) begin
            cent_nxt = wr_data[CENT_BIT];
        end else if (steer_clear) begin
            cent_nxt = 1'b0;
        end else begin
            cent_nxt = cent_q;
        end
    end

    // A control access clears the flag even in the expiry cycle
    always_comb begin
        if (ctrl_acc) begin
            fired_nxt = 1'b0;
        end else if (fire) begin
            fired_nxt = 1'b1;
        end else begin
            fired_nxt = fired_q;
        end
    end

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_CTRL:  rd_mux = ctrl_q;
            A_FLAG:  rd_mux[FLAG_BIT] = fired_q;
            A_AUX:   rd_mux[CENT_BIT] = cent_q;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            cent_q  <= 1'b0;
            fired_q <= 1'b0;
            rd_q    <= '0;
        end else begin
            ctrl_q  <= ctrl_nxt;
            cent_q  <= cent_nxt;
            fired_q <= fired_nxt;
            if (rd_en) begin
                rd_q <= rd_mux;
            end
        end
    end

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2,
    parameter int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              dec,
    input  logic [MULT_W-1:0] mult,
    input  logic [RES_W-1:0]  res,
    output logic              load_zero,
    output logic              last
);
    localparam int RES_STEPS = 1 << RES_W;

    logic [CNT_W-1:0] timeout;
    logic [CNT_W-1:0] cnt_q;

    // Each resolution step scales the multiplier by four: a shift by 2*step
    always_comb begin
        timeout = '0;
        for (int i = 0; i < RES_STEPS; i++) begin
            if (res == RES_W'(i)) begin
                timeout = CNT_W'(mult) << (2 * i);
            end
        end
    end

    assign load_zero = (mult == '0);
    assign last      = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= timeout;
        end else if (dec) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_acc,
    input  logic reload_zero,
    input  logic tick,
    input  logic last,
    input  logic steer,
    output logic load,
    output logic dec,
    output logic fire,
    output logic sys_reset_req,
    output logic irq_pulse
);
    import wdt_pkg::*;

    wd_state_e state_q;
    wd_state_e state_d;

    // Next-state selection; a control access overrides every state
    always_comb begin
        state_d = state_q;
        if (ctrl_acc) begin
            state_d = reload_zero ? WD_OFF : WD_RUN;
        end else begin
            unique case (state_q)
                WD_OFF:  state_d = WD_OFF;
                WD_RUN:  state_d = (tick && last) ? WD_FIRE : WD_RUN;
                WD_FIRE: state_d = WD_HALT;
                WD_HALT: state_d = WD_HALT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Moore outputs and counter controls
    always_comb begin
        load          = ctrl_acc && !reload_zero;
        dec           = 1'b0;
        fire          = 1'b0;
        sys_reset_req = 1'b0;
        irq_pulse     = 1'b0;
        unique case (state_q)
            WD_OFF:  ;
            WD_RUN:  dec = tick && !ctrl_acc;
            WD_FIRE: begin
                fire          = 1'b1;
                sys_reset_req = steer;
                irq_pulse     = !steer;
            end
            WD_HALT: ;
        endcase
    end

endmodule

// File: rtl/wdog_steer.sv
module wdog_steer #(
    parameter int  MULT_W = 5,
    parameter int  RES_W  = 2,
    parameter int  ADDR_W = 2,
    localparam int DATA_W = MULT_W + RES_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_16hz,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              sys_reset_req,
    output logic              irq_pulse
);
    localparam int CNT_W     = MULT_W + 2 * ((1 << RES_W) - 1);
    localparam int STEER_BIT = DATA_W - 1;

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] ctrl_nxt;
    logic              ctrl_acc;
    logic              fired_q;
    logic              fire;
    logic              load;
    logic              dec;
    logic              load_zero;
    logic              last;

    wdt_regfile #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wr_data  (wr_data),
        .fire     (fire),
        .ctrl_q   (ctrl_q),
        .ctrl_nxt (ctrl_nxt),
        .ctrl_acc (ctrl_acc),
        .fired_q  (fired_q),
        .rd_q     (rd_data)
    );

    // The reload uses the byte the control register holds after this cycle
    wdt_countdown #(
        .MULT_W (MULT_W),
        .RES_W  (RES_W),
        .CNT_W  (CNT_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .dec       (dec),
        .mult      (ctrl_nxt[RES_W+MULT_W-1:RES_W]),
        .res       (ctrl_nxt[RES_W-1:0]),
        .load_zero (load_zero),
        .last      (last)
    );

    wdt_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_acc      (ctrl_acc),
        .reload_zero   (load_zero),
        .tick          (tick_16hz),
        .last          (last),
        .steer         (ctrl_q[STEER_BIT]),
        .load          (load),
        .dec           (dec),
        .fire          (fire),
        .sys_reset_req (sys_reset_req),
        .irq_pulse     (irq_pulse)
    );

endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic              sys_reset_req,
    input logic              irq_pulse,
    input logic              fired_q,
    input logic [DATA_W-1:0] ctrl_q
);
    logic ctrl_sel;
    logic flag_sel;

    assign ctrl_sel = (bus_addr == ADDR_W'(0));
    assign flag_sel = (bus_addr == ADDR_W'(1));

    // R6 R7
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sys_reset_req && irq_pulse));

    // R6 R9
    rst_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> !sys_reset_req);

    // R7 R9
    irq_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R3
    ctrl_wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctrl_sel) |=> !(sys_reset_req || irq_pulse));

    // R5
    fire_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sys_reset_req || irq_pulse) && !((wr_en || rd_en) && ctrl_sel)) |=> fired_q);

    // R6
    steer_clears_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_reset_req && !(wr_en && ctrl_sel)) |=> (ctrl_q == '0));

    // R4
    ctrl_rd_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ctrl_sel) |=> !fired_q);

    // R8
    flag_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && flag_sel && !rd_en && !sys_reset_req && !irq_pulse) |=> $stable(fired_q));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!sys_reset_req && !irq_pulse));

endmodule

bind wdog_steer wdog_steer_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .sys_reset_req (sys_reset_req),
    .irq_pulse     (irq_pulse),
    .fired_q       (fired_q),
    .ctrl_q        (ctrl_q)
);

// File: tb/wdog_steer_bench.sv
`timescale 1ns/1ps
module wdog_steer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_16hz = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       sys_reset_req;
    logic       irq_pulse;

    int n_checks = 0;
    int n_errors = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;

    wdog_steer u_wdog_steer (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_16hz     (tick_16hz),
        .bus_addr      (bus_addr),
        .wr_en         (wr_en),
        .rd_en         (rd_en),
        .wr_data       (wr_data),
        .rd_data       (rd_data),
        .sys_reset_req (sys_reset_req),
        .irq_pulse     (irq_pulse)
    );

    always #4 clk = ~clk;

    // ---------------- expected-value helpers ----------------
    function automatic int tmo_ticks(input logic [7:0] v);
        return int'(v[6:2]) * (1 << (2 * int'(v[1:0])));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- cycle model (from the requirements) ----------------
    int         m_state = 0;   // 0 off, 1 run, 2 fire, 3 halt
    int         m_cnt = 0;
    logic [7:0] m_ctrl = 8'd0;
    logic       m_cent = 1'b0;
    logic       m_flag = 1'b0;
    logic [7:0] m_rd = 8'd0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_ctrl = 8'd0;
            m_cent = 1'b0; m_flag = 1'b0; m_rd = 8'd0;
        end else begin
            bit         ex;
            bit         acc0;
            logic [7:0] nctrl;
            logic       ncent;
            logic       nflag;
            ex   = (m_state == 2);
            acc0 = (wr_en || rd_en) && bus_addr == 2'd0;
            if (rd_en) begin
                case (bus_addr)
                    2'd0: m_rd = m_ctrl;
                    2'd1: m_rd = {m_flag, 7'd0};
                    2'd2: m_rd = {1'b0, m_cent, 6'd0};
                    default: m_rd = 8'd0;
                endcase
            end
            nctrl = (wr_en && bus_addr == 2'd0) ? wr_data : (ex && m_ctrl[7]) ? 8'd0 : m_ctrl;
            ncent = (wr_en && bus_addr == 2'd2) ? wr_data[6] : (ex && m_ctrl[7]) ? 1'b0 : m_cent;
            nflag = acc0 ? 1'b0 : ex ? 1'b1 : m_flag;
            if (acc0) begin
                if (tmo_ticks(nctrl) != 0) begin
                    m_state = 1; m_cnt = tmo_ticks(nctrl);
                end else begin
                    m_state = 0;
                end
            end else begin
                case (m_state)
                    1: if (tick_16hz) begin
                           if (m_cnt == 1) m_state = 2;
                           else m_cnt = m_cnt - 1;
                       end
                    2: m_state = 3;
                    default: ;
                endcase
            end
            m_ctrl = nctrl; m_cent = ncent; m_flag = nflag;
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            check("R6 model sys_reset_req", int'(sys_reset_req), int'(m_state == 2 && m_ctrl[7]));
            check("R7 model irq_pulse", int'(irq_pulse), int'(m_state == 2 && !m_ctrl[7]));
            check("R12 model rd_data", int'(rd_data), int'(m_rd));
        end
    end

    // ---------------- bus tasks (called just after a falling edge) ----------------
    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input bit tk = 1'b0);
        bus_addr = a; wr_data = d; wr_en = 1'b1; tick_16hz = tk;
        @(negedge clk);
        wr_en = 1'b0; tick_16hz = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    // n back-to-back ticks; counts pulses seen after each edge
    task automatic ticks(input int n, output int n_rst, output int n_irq);
        n_rst = 0; n_irq = 0;
        for (int i = 0; i < n; i++) begin
            tick_16hz = 1'b1;
            @(negedge clk);
            tick_16hz = 1'b0;
            n_rst += int'(sys_reset_req);
            n_irq += int'(irq_pulse);
        end
    endtask

    task automatic do_reset();
        cmp_en = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        finished = 1'b1;
        $finish;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    // ---------------- directed and random stimulus ----------------
    initial begin
        logic [7:0] d;
        int nr;
        int ni;
        void'($urandom(32'd20240611));
        @(negedge clk);
        @(negedge clk);
        // R10: outputs low while in reset
        check("R10 reset sys_reset_req", int'(sys_reset_req), 0);
        check("R10 reset irq_pulse", int'(irq_pulse), 0);
        check("R10 reset rd_data", int'(rd_data), 0);
        do_reset();
        bus_rd(2'd0, d); check("R10 ctrl after reset", d, 8'h00);
        bus_rd(2'd1, d); check("R10 flag after reset", d, 8'h00);

        // R3 R1 R7: 0x05 -> M=1, S=1 -> 4 ticks, interrupt steering
        bus_wr(2'd0, 8'h05);
        bus_rd(2'd0, d); check("R3 ctrl readback", d, 8'h05);
        ticks(3, nr, ni); check("R1 no early expiry", nr + ni, 0);
        ticks(1, nr, ni); check("R7 irq on 4th tick", ni, 1); check("R7 no reset", nr, 0);
        @(negedge clk); check("R7 irq one clock", int'(irq_pulse), 0);
        bus_rd(2'd1, d); check("R5 flag set", d, 8'h80);
        // R9: halted after expiry
        ticks(20, nr, ni); check("R9 no pulse after expiry", nr + ni, 0);
        // R8: flag byte ignores writes
        bus_wr(2'd1, 8'h00);
        bus_rd(2'd1, d); check("R8 flag write ignored", d, 8'h80);
        bus_rd(2'd0, d); check("R7 ctrl kept", d, 8'h05);
        bus_rd(2'd1, d); check("R4 read clears flag", d, 8'h00);
        bus_wr(2'd1, 8'hFF);
        bus_rd(2'd1, d); check("R8 flag write ones ignored", d, 8'h00);
        // R4: the ctrl read above rearmed 4 ticks; let it expire to clear the run
        ticks(4, nr, ni); check("R4 rearm by read expires", ni, 1);

        // R6 R12: century bit, reset steering, 0x84 -> 1 tick
        bus_wr(2'd2, 8'hFF);
        bus_rd(2'd2, d); check("R12 aux only bit 6", d, 8'h40);
        bus_wr(2'd0, 8'h84);
        ticks(1, nr, ni); check("R6 reset on 1st tick", nr, 1); check("R6 no irq", ni, 0);
        @(negedge clk); check("R6 reset one clock", int'(sys_reset_req), 0);
        bus_rd(2'd2, d); check("R6 century cleared", d, 8'h00);
        bus_rd(2'd1, d); check("R5 flag after reset expiry", d, 8'h80);
        bus_rd(2'd0, d); check("R6 ctrl cleared", d, 8'h00);
        ticks(30, nr, ni); check("R6 disarmed after clear", nr + ni, 0);

        // R2: zero multiplier disables
        bus_wr(2'd0, 8'h00);
        ticks(50, nr, ni); check("R2 0x00 disabled", nr + ni, 0);
        bus_wr(2'd0, 8'h83);
        ticks(50, nr, ni); check("R2 0x83 disabled", nr + ni, 0);

        // R4: read in mid-count restarts (0x09 -> 8 ticks)
        bus_wr(2'd0, 8'h09);
        ticks(6, nr, ni);
        bus_rd(2'd0, d); check("R4 read value", d, 8'h09);
        ticks(7, nr, ni); check("R4 restart by read", nr + ni, 0);
        ticks(1, nr, ni); check("R4 expiry after restart", ni, 1);
        // R3: write in mid-count restarts
        bus_wr(2'd0, 8'h09);
        ticks(5, nr, ni);
        bus_wr(2'd0, 8'h09);
        ticks(7, nr, ni); check("R3 restart by write", nr + ni, 0);
        ticks(1, nr, ni); check("R3 expiry after restart", ni, 1);

        // R11: tick in the same cycle as the write is ignored (0x04 -> 1 tick)
        bus_wr(2'd0, 8'h04, 1'b1);
        check("R11 tick with write ignored", int'(irq_pulse), 0);
        ticks(1, nr, ni); check("R11 expiry on next tick", ni, 1);
        // R11: read during the FIRE cycle of a reset-steered expiry
        bus_wr(2'd2, 8'h40);
        bus_wr(2'd0, 8'h85);
        ticks(4, nr, ni); check("R11 reset pulse", nr, 1);
        bus_rd(2'd0, d); check("R11 read in fire returns old", d, 8'h85);
        bus_rd(2'd1, d); check("R11 flag stays clear", d, 8'h00);
        bus_rd(2'd0, d); check("R11 ctrl cleared", d, 8'h00);
        ticks(40, nr, ni); check("R11 no rearm from stale value", nr + ni, 0);
        bus_rd(2'd3, d); check("R12 addr 3 reads zero", d, 8'h00);
        bus_wr(2'd3, 8'hA5);
        bus_rd(2'd3, d); check("R12 addr 3 write ignored", d, 8'h00);

        // R1: largest timeout 0x7F -> 31*64 = 1984 ticks
        bus_wr(2'd0, 8'h7F);
        ticks(1983, nr, ni); check("R1 max timeout early", nr + ni, 0);
        ticks(1, nr, ni); check("R1 max timeout expiry", ni, 1);

        // R10: reset in mid-count
        bus_wr(2'd0, 8'h84);
        do_reset();
        ticks(5, nr, ni); check("R10 no pulse after reset", nr + ni, 0);
        bus_rd(2'd0, d); check("R10 ctrl zero after reset", d, 8'h00);

        // random phase, checked against the cycle model
        for (int c = 0; c < 6000; c++) begin
            int op;
            tick_16hz = 1'($urandom % 2);
            op = int'($urandom % 12);
            bus_addr = ($urandom % 3 == 0) ? 2'($urandom % 4) : 2'd0;
            if (op == 0) begin
                wr_en = 1'b1;
                wr_data = (bus_addr == 2'd0)
                        ? {1'($urandom % 2), 3'd0, 2'($urandom % 4), 2'($urandom % 2)}
                        : 8'($urandom);
            end else if (op == 1) begin
                rd_en = 1'b1;
            end
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0; tick_16hz = 1'b0;
        end
        @(negedge clk);
        finish_run();
    end

endmodule